// File: doc/BRIEF.md
# Byte ALU with Decimal Adjust

This block is the arithmetic and logic stage of a small accumulator-style processor core. An instruction decoder presents a four-bit operation class, two byte operands and the current carry and half-carry flags; the block returns the byte result combinationally in the same cycle. It also updates a five-bit flag register (negative, overflow, half-carry, zero, carry) on the next rising clock edge when the operation is marked valid.

The operation set covers add and subtract with carry, compare, the three bitwise operations, four shift and rotate forms, nibble swap, and the two decimal correction steps that follow a byte add or byte subtract. Each class writes only its own subset of flags. Flags that an operation does not write keep their registered value. Operand fetch, addressing, write-back and decode of the raw instruction stay in the surrounding core.

Top module: `byte_alu`

## Requirements
- R1: While rstN is low, and on the first cycle after it rises, flagN, flagV, flagH, flagZ and flagC are all 0.
- R2: Class 0 (add): result = (opA + opB + cIn) mod 256. C takes the ninth sum bit. H takes bit 4 of (opA ^ opB ^ sum), which is the carry out of bit 3. V is set when both operands share a sign bit that differs from result bit 7. Every op that writes N and Z sets N to result bit 7 and Z when the result is 0x00.
- R3: Class 1 (subtract with borrow) behaves as class 0 with opB replaced by its bitwise complement, with cIn still as the carry in. It updates all five flags the same way.
- R4: Class 2 (compare) drives result = (opA - opB) mod 256. It updates N and Z from that value and sets C when opA >= opB. V and H keep their values.
- R5: Classes 3, 4 and 5 give opA AND, OR and XOR opB. They update only N and Z. V, H and C keep their values.
- R6: Class 6 shifts opA left with 0 into bit 0. Class 7 rotates left with cIn into bit 0. In both, opA bit 7 goes to C. Class 8 shifts right with 0 into bit 7. Class 9 rotates right with cIn into bit 7. In both, opA bit 0 goes to C. Shifts update N, Z and C only.
- R7: Class 10 swaps the upper and lower nibbles of opA. It updates N and Z only.
- R8: Class 11 (adjust after add) works in two steps. Step 1: if opA > 0x99 or cIn is 1, it adds 0x60 and sets C; otherwise C = cIn. Step 2: it adds 0x06 if the low nibble of the step-1 value exceeds 9 or hIn is 1. It updates N, Z and C.
- R9: Class 12 (adjust after subtract) works in two steps. Step 1: if opA > 0x99 or cIn is 0, it subtracts 0x60 and clears C; otherwise C = cIn. Step 2: it subtracts 0x06 if the low nibble of the step-1 value exceeds 9 or hIn is 0. It updates N, Z and C.
- R10: Flags change only on a rising clock edge with opValid high. With opValid low, all five flags hold their values.
- R11: Classes 13 to 15 are reserved. They drive result = opA and leave all five flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Active-low synchronous reset of the flags |
| opValid | input | 1 | Commit the flags of this cycle's operation |
| opClass | input | 4 | Operation class code (see requirements) |
| opA | input | 8 | First operand / accumulator value |
| opB | input | 8 | Second operand |
| cIn | input | 1 | Incoming carry flag |
| hIn | input | 1 | Incoming half-carry flag |
| result | output | 8 | Combinational byte result |
| flagN | output | 1 | Registered negative flag |
| flagV | output | 1 | Registered overflow flag |
| flagH | output | 1 | Registered half-carry flag |
| flagZ | output | 1 | Registered zero flag |
| flagC | output | 1 | Registered carry flag |

## Verification
Random operand pairs over all sixteen class codes mix wrapping sums with clean ones, so they tell the carry path apart from the half-carry and overflow derivations. Directed vectors aim at signed-overflow boundaries (0x7F+1, 0x80-1), equal and reversed compare operands, and decimal inputs just above 0x99. Low-nibble values of 0x0A to 0x0F with both hIn levels show whether the second decimal step looks at the already adjusted value. Random cycles with opValid low, plus the reserved codes, show that the flags hold when an operation must not write them.

// File: rtl/byte_alu_pkg.sv
`timescale 1ns/1ps
package byte_alu_pkg;
  localparam int DATA_W = 8;
  localparam int CLASS_W = 4;

  localparam logic [CLASS_W-1:0] OP_ADD = 4'd0;
  localparam logic [CLASS_W-1:0] OP_SUB = 4'd1;
  localparam logic [CLASS_W-1:0] OP_CMP = 4'd2;
  localparam logic [CLASS_W-1:0] OP_AND = 4'd3;
  localparam logic [CLASS_W-1:0] OP_OR  = 4'd4;
  localparam logic [CLASS_W-1:0] OP_XOR = 4'd5;
  localparam logic [CLASS_W-1:0] OP_SHL = 4'd6;
  localparam logic [CLASS_W-1:0] OP_RTL = 4'd7;
  localparam logic [CLASS_W-1:0] OP_SHR = 4'd8;
  localparam logic [CLASS_W-1:0] OP_RTR = 4'd9;
  localparam logic [CLASS_W-1:0] OP_SWP = 4'd10;
  localparam logic [CLASS_W-1:0] OP_DCA = 4'd11;
  localparam logic [CLASS_W-1:0] OP_DCS = 4'd12;

  typedef enum logic [1:0] {
    LOGIC_AND = 2'd0,
    LOGIC_OR  = 2'd1,
    LOGIC_XOR = 2'd2
  } logicSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      useArith;
    logic      invB;
    logic      forceCarry;
    logic      useLogic;
    logicSel_e logicSel;
    logic      useShift;
    logic      shiftLeft;
    logic      shiftCarry;
    logic      useSwap;
    logic      useDec;
    logic      decSub;
    logic      wrNZ;
    logic      wrVH;
    logic      wrC;
  } aluCtrl_t;
endpackage

// File: rtl/byte_alu_ctrl.sv
`timescale 1ns/1ps
module byte_alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic               opValid,
  input  logic [CLASS_W-1:0] opClass,
  output aluCtrl_t           ctrl
);
  aluCtrl_t dec;

  always_comb begin
    dec = '0;
    dec.logicSel = LOGIC_AND;
    case (opClass)
      OP_ADD: begin dec.useArith = 1'b1; dec.wrNZ = 1'b1; dec.wrVH = 1'b1; dec.wrC = 1'b1; end
      OP_SUB: begin dec.useArith = 1'b1; dec.invB = 1'b1;
                    dec.wrNZ = 1'b1; dec.wrVH = 1'b1; dec.wrC = 1'b1; end
      OP_CMP: begin dec.useArith = 1'b1; dec.invB = 1'b1; dec.forceCarry = 1'b1;
                    dec.wrNZ = 1'b1; dec.wrC = 1'b1; end
      OP_AND: begin dec.useLogic = 1'b1; dec.logicSel = LOGIC_AND; dec.wrNZ = 1'b1; end
      OP_OR:  begin dec.useLogic = 1'b1; dec.logicSel = LOGIC_OR;  dec.wrNZ = 1'b1; end
      OP_XOR: begin dec.useLogic = 1'b1; dec.logicSel = LOGIC_XOR; dec.wrNZ = 1'b1; end
      OP_SHL: begin dec.useShift = 1'b1; dec.shiftLeft = 1'b1; dec.wrNZ = 1'b1; dec.wrC = 1'b1; end
      OP_RTL: begin dec.useShift = 1'b1; dec.shiftLeft = 1'b1; dec.shiftCarry = 1'b1;
                    dec.wrNZ = 1'b1; dec.wrC = 1'b1; end
      OP_SHR: begin dec.useShift = 1'b1; dec.wrNZ = 1'b1; dec.wrC = 1'b1; end
      OP_RTR: begin dec.useShift = 1'b1; dec.shiftCarry = 1'b1; dec.wrNZ = 1'b1; dec.wrC = 1'b1; end
      OP_SWP: begin dec.useSwap = 1'b1; dec.wrNZ = 1'b1; end
      OP_DCA: begin dec.useDec = 1'b1; dec.wrNZ = 1'b1; dec.wrC = 1'b1; end
      OP_DCS: begin dec.useDec = 1'b1; dec.decSub = 1'b1; dec.wrNZ = 1'b1; dec.wrC = 1'b1; end
      default: ; // reserved: no unit, no flag write
    endcase
  end

  always_comb begin
    ctrl      = dec;
    ctrl.wrNZ = dec.wrNZ & opValid;
    ctrl.wrVH = dec.wrVH & opValid;
    ctrl.wrC  = dec.wrC  & opValid;
  end
endmodule

// File: rtl/byte_alu_dp.sv
`timescale 1ns/1ps
module byte_alu_dp
  import byte_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              cIn,
  input  logic              hIn,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagV,
  output logic              flagH,
  output logic              flagZ,
  output logic              flagC
);
  localparam int SUM_W = DATA_W + 1;
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] DEC_HI  = 8'h60;
  localparam logic [DATA_W-1:0] DEC_LO  = 8'h06;
  localparam logic [DATA_W-1:0] DEC_MAX = 8'h99;

  // adder shared by add, subtract and compare
  logic [DATA_W-1:0] bOp;
  logic              carryIn;
  logic [SUM_W-1:0]  sum;
  logic              hArith, vArith;

  assign bOp     = ctrl.invB ? ~opB : opB;
  assign carryIn = ctrl.forceCarry ? 1'b1 : cIn;
  assign sum     = {1'b0, opA} + {1'b0, bOp} + {{DATA_W{1'b0}}, carryIn};
  assign hArith  = opA[4] ^ bOp[4] ^ sum[4];
  assign vArith  = (opA[MSB] == bOp[MSB]) && (sum[MSB] != opA[MSB]);

  // bitwise unit
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    case (ctrl.logicSel)
      LOGIC_OR:  logicRes = opA | opB;
      LOGIC_XOR: logicRes = opA ^ opB;
      default:   logicRes = opA & opB;
    endcase
  end

  // shifter
  logic              fillBit;
  logic [DATA_W-1:0] shiftRes;
  logic              shiftC;
  assign fillBit  = ctrl.shiftCarry & cIn;
  assign shiftRes = ctrl.shiftLeft ? {opA[MSB-1:0], fillBit} : {fillBit, opA[MSB:1]};
  assign shiftC   = ctrl.shiftLeft ? opA[MSB] : opA[0];

  // nibble swap
  logic [DATA_W-1:0] swapRes;
  assign swapRes = {opA[3:0], opA[MSB:4]};

  // decimal adjust: second step tests the step-one value
  logic              decStep1, decStep2, decC;
  logic [DATA_W-1:0] decMid, decRes;
  always_comb begin
    if (ctrl.decSub) begin
      decStep1 = (opA > DEC_MAX) || !cIn;
      decMid   = decStep1 ? opA - DEC_HI : opA;
      decC     = decStep1 ? 1'b0 : cIn;
      decStep2 = (decMid[3:0] > 4'd9) || !hIn;
      decRes   = decStep2 ? decMid - DEC_LO : decMid;
    end else begin
      decStep1 = (opA > DEC_MAX) || cIn;
      decMid   = decStep1 ? opA + DEC_HI : opA;
      decC     = decStep1 ? 1'b1 : cIn;
      decStep2 = (decMid[3:0] > 4'd9) || hIn;
      decRes   = decStep2 ? decMid + DEC_LO : decMid;
    end
  end

  // result and carry select
  logic cNext;
  always_comb begin
    result = opA;
    cNext  = flagC;
    if (ctrl.useArith) begin
      result = sum[DATA_W-1:0];
      cNext  = sum[DATA_W];
    end else if (ctrl.useLogic) begin
      result = logicRes;
    end else if (ctrl.useShift) begin
      result = shiftRes;
      cNext  = shiftC;
    end else if (ctrl.useSwap) begin
      result = swapRes;
    end else if (ctrl.useDec) begin
      result = decRes;
      cNext  = decC;
    end
  end

  // flag register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagN <= 1'b0;
      flagZ <= 1'b0;
    end else if (ctrl.wrNZ) begin
      flagN <= result[MSB];
      flagZ <= (result == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagV <= 1'b0;
      flagH <= 1'b0;
    end else if (ctrl.wrVH) begin
      flagV <= vArith;
      flagH <= hArith;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagC <= 1'b0;
    else if (ctrl.wrC) flagC <= cNext;
  end

  // R2: zero flag follows the committed result
  assert_zero_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrNZ |=> (flagZ == ($past(result) == '0)));
endmodule

// File: rtl/byte_alu.sv
`timescale 1ns/1ps
module byte_alu
  import byte_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [3:0]  opClass,
  input  logic [7:0]  opA,
  input  logic [7:0]  opB,
  input  logic        cIn,
  input  logic        hIn,
  output logic [7:0]  result,
  output logic        flagN,
  output logic        flagV,
  output logic        flagH,
  output logic        flagZ,
  output logic        flagC
);
  aluCtrl_t ctrl;

  byte_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opClass (opClass),
    .ctrl    (ctrl)
  );

  byte_alu_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .cIn    (cIn),
    .hIn    (hIn),
    .result (result),
    .flagN  (flagN),
    .flagV  (flagV),
    .flagH  (flagH),
    .flagZ  (flagZ),
    .flagC  (flagC)
  );

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(flagN) && $stable(flagV) && $stable(flagH) && $stable(flagZ) && $stable(flagC)));

  assert_reserved_passes_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opClass > OP_DCS) |-> (result == opA));

  assert_reserved_keeps_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass > OP_DCS) |=> ($stable(flagN) && $stable(flagV) && $stable(flagH) && $stable(flagZ) && $stable(flagC)));

  assert_compare_keeps_vh_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == OP_CMP) |=> ($stable(flagV) && $stable(flagH)));

  assert_bitwise_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opClass == OP_AND || opClass == OP_OR || opClass == OP_XOR))
      |=> ($stable(flagV) && $stable(flagH) && $stable(flagC)));

  assert_shl_carry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == OP_SHL) |=> (flagC == $past(opA[7])));

  assert_swap_sign_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == OP_SWP) |=> (flagN == $past(opA[3])));

  assert_dca_sets_c_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == OP_DCA && opA > 8'h99) |=> flagC);

  assert_dcs_clears_c_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == OP_DCS && opA > 8'h99) |=> !flagC);
endmodule

// File: tb/byte_alu_test.sv
`timescale 1ns/1ps
module byte_alu_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opClass = 4'd0;
  logic [7:0] opA = 8'd0, opB = 8'd0;
  logic       cIn = 1'b0, hIn = 1'b0;
  logic [7:0] result;
  logic       flagN, flagV, flagH, flagZ, flagC;

  int checks = 0;
  int errors = 0;
  logic [4:0] expFlags = 5'b0; // {N,V,H,Z,C}
  bit finished = 0;

  always #4 clk = ~clk;

  byte_alu uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .opA(opA), .opB(opB), .cIn(cIn), .hIn(hIn), .result(result),
    .flagN(flagN), .flagV(flagV), .flagH(flagH), .flagZ(flagZ), .flagC(flagC)
  );

  function automatic string reqOf(input int op);
    case (op)
      0: return "R2";  1: return "R3";  2: return "R4";
      3, 4, 5: return "R5";
      6, 7, 8, 9: return "R6";
      10: return "R7"; 11: return "R8"; 12: return "R9";
      default: return "R11";
    endcase
  endfunction

  // returns {result[7:0], N, V, H, Z, C}
  function automatic logic [12:0] model(input int op, input int a, input int b,
                                        input int c, input int h, input logic [4:0] fl);
    int r, s, bb, t, cc;
    logic n, v, hh, z, co;
    {n, v, hh, z, co} = fl;
    r = a;
    case (op)
      0, 1: begin
        bb = (op == 1) ? (~b) & 255 : b;
        s = a + bb + c;
        r = s & 255; co = (s >> 8) & 1;
        hh = ((a ^ bb ^ s) >> 4) & 1;
        v = (((a ^ s) & (bb ^ s) & 128) != 0);
      end
      2: begin r = (a - b) & 255; co = (a >= b); end
      3: r = a & b;
      4: r = a | b;
      5: r = a ^ b;
      6: begin r = (a << 1) & 255; co = (a >> 7) & 1; end
      7: begin r = ((a << 1) & 255) | c; co = (a >> 7) & 1; end
      8: begin r = a >> 1; co = a & 1; end
      9: begin r = (a >> 1) | (c << 7); co = a & 1; end
      10: r = ((a & 15) << 4) | (a >> 4);
      11: begin
        t = a; cc = c;
        if (t > 153 || c != 0) begin t = t + 96; cc = 1; end
        if ((t & 15) > 9 || h != 0) t = t + 6;
        r = t & 255; co = cc[0];
      end
      12: begin
        t = a; cc = c;
        if (t > 153 || c == 0) begin t = t - 96; cc = 0; end
        if ((t & 15) > 9 || h == 0) t = t - 6;
        r = t & 255; co = cc[0];
      end
      default: r = a;
    endcase
    if (op <= 12) begin n = r[7]; z = (r == 0); end
    return {r[7:0], n, v, hh, z, co};
  endfunction

  task automatic runOp(input int op, input int a, input int b, input int c,
                       input int h, input bit valid);
    logic [12:0] exp;
    @(negedge clk);
    opClass = op[3:0]; opA = a[7:0]; opB = b[7:0];
    cIn = c[0]; hIn = h[0]; opValid = valid;
    exp = model(op, a, b, c, h, expFlags);
    #1;
    checks++;
    if (result !== exp[12:5]) begin
      errors++;
      $display("FAIL %s result op=%0d a=%h b=%h c=%0d h=%0d: got %h expected %h",
               reqOf(op), op, a, b, c, h, result, exp[12:5]);
    end
    @(posedge clk);
    #1;
    if (valid) expFlags = exp[4:0];
    checks++;
    if ({flagN, flagV, flagH, flagZ, flagC} !== expFlags) begin
      errors++;
      $display("FAIL %s flags op=%0d valid=%0d a=%h b=%h c=%0d h=%0d: got %b expected %b",
               valid ? reqOf(op) : "R10", op, valid, a, b, c, h,
               {flagN, flagV, flagH, flagZ, flagC}, expFlags);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    checks++; // R1 reset state
    if ({flagN, flagV, flagH, flagZ, flagC} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset flags: got %b expected 00000", {flagN, flagV, flagH, flagZ, flagC});
    end
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checks++; // R1 first cycle after reset
    if ({flagN, flagV, flagH, flagZ, flagC} !== 5'b0) begin
      errors++;
      $display("FAIL R1 post-reset flags: got %b expected 00000", {flagN, flagV, flagH, flagZ, flagC});
    end

    // R2 overflow, half carry, wrap to zero
    runOp(0, 8'h7F, 8'h01, 0, 0, 1);
    runOp(0, 8'hFF, 8'h01, 0, 0, 1);
    runOp(0, 8'h80, 8'h80, 1, 0, 1);
    // R3 borrow cases
    runOp(1, 8'h00, 8'h01, 1, 0, 1);
    runOp(1, 8'h80, 8'h01, 1, 0, 1);
    runOp(1, 8'h50, 8'h50, 0, 0, 1);
    // R4 equal, less, greater; V/H must survive from previous op
    runOp(0, 8'h7F, 8'h01, 0, 0, 1);
    runOp(2, 8'h42, 8'h42, 0, 0, 1);
    runOp(2, 8'h10, 8'h20, 1, 1, 1);
    runOp(2, 8'h20, 8'h10, 0, 0, 1);
    // R5 bitwise keeps C
    runOp(6, 8'h80, 0, 0, 0, 1);
    runOp(3, 8'hF0, 8'h0F, 0, 0, 1);
    runOp(4, 8'h80, 8'h01, 0, 0, 1);
    runOp(5, 8'hAA, 8'hAA, 1, 1, 1);
    // R6 shifts with fill bit
    runOp(7, 8'h80, 0, 1, 0, 1);
    runOp(8, 8'h01, 0, 1, 0, 1);
    runOp(9, 8'h01, 0, 1, 0, 1);
    // R7 swap
    runOp(10, 8'h08, 0, 0, 0, 1);
    runOp(10, 8'h00, 0, 1, 1, 1);
    // R8 decimal adjust after add, second step on adjusted value
    runOp(11, 8'h9A, 0, 0, 0, 1);
    runOp(11, 8'h0F, 0, 0, 0, 1);
    runOp(11, 8'h12, 0, 1, 1, 1);
    runOp(11, 8'hA5, 0, 0, 1, 1);
    // R9 decimal adjust after subtract
    runOp(12, 8'h9A, 0, 1, 1, 1);
    runOp(12, 8'h0F, 0, 1, 1, 1);
    runOp(12, 8'h45, 0, 0, 0, 1);
    runOp(12, 8'h66, 0, 1, 0, 1);
    // R10 idle holds, R11 reserved
    runOp(0, 8'hFF, 8'hFF, 1, 0, 0);
    runOp(13, 8'h00, 8'h00, 1, 1, 1);
    runOp(15, 8'h5C, 8'h11, 0, 0, 1);

    // random mix over all classes
    for (int i = 0; i < 12000; i++) begin
      int op, a, b, c, h;
      bit v;
      op = $urandom_range(0, 15);
      a  = $urandom_range(0, 255);
      b  = $urandom_range(0, 255);
      c  = $urandom_range(0, 1);
      h  = $urandom_range(0, 1);
      v  = ($urandom_range(0, 7) != 0);
      runOp(op, a, b, c, h, v);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule